// File: doc/BRIEF.md
# Interleaved Multi-Bank Line Fill Controller

This block fetches one cache line from a main memory made of several narrow banks. Consecutive chunks of the address space sit in consecutive banks. A caller pulses a start request together with a line index. The controller then works through the line in one or more iterations. In each iteration it first spends a fixed bank-decode window. It then holds read enables and row addresses on every bank it needs for the bank latency, and captures the returned chunks into a line buffer in the final cycle of that window.

The decode window lasts half the bank count in cycles and does not get shorter when fewer banks are used. A line larger than one sweep of the banks therefore costs a whole iteration per sweep, and that includes a short final sweep. With the defaults (64-byte line, 24 banks of 2 bytes, 12 decode cycles, 80 latency cycles) one fill takes two iterations and 184 busy cycles. When the line is assembled, a one-cycle done pulse marks the line bus as valid.

Top module: `line_fill_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, busy_o, done_o and every bank enable are low and line_o is all zeros.
- R2: A start request is taken only when the controller is idle. A start seen while busy or during the done cycle changes neither the fetched line nor the fill timing.
- R3: The number of iterations is ceil(LINE_BYTES / (NUM_BANKS*BANK_BYTES)). Each iteration opens with DECODE_CYCLES cycles in which all bank enables are low. It then holds its enables and rows stable for BANK_LATENCY cycles.
- R4: After an accepted start, busy_o is high for exactly iterations*(DECODE_CYCLES+BANK_LATENCY) consecutive cycles (184 with the defaults). done_o is high for exactly one cycle right after that, and busy_o is low in that cycle.
- R5: Chunk j of line L has global chunk index g = L*(LINE_BYTES/BANK_BYTES) + j. It is read from bank g mod NUM_BANKS at row g div NUM_BANKS, and bank b drives row bits [b*ROW_W +: ROW_W].
- R6: Every iteration except the last enables all NUM_BANKS banks. The last one enables only the banks that hold the remaining chunks (8 with the defaults), and all other enables stay low.
- R7: Bits [j*BANK_BYTES*8 +: BANK_BYTES*8] of line_o hold chunk j. The line is complete when done_o is high and is held unchanged until the next fill writes it.
- R8: Bank data is sampled in the last cycle of the BANK_LATENCY window, so a bank only has to drive valid data once it has been enabled for BANK_LATENCY cycles.
- R9: The controller returns to idle in the cycle after done_o. A start held high across the done cycle is accepted in that idle cycle, and busy_o rises in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Fill request, taken only when idle |
| line_idx_i | input | IDX_W | Index of the line to fetch |
| busy_o | output | 1 | High during decode and access phases |
| done_o | output | 1 | One-cycle pulse, line_o complete |
| bank_en_o | output | NUM_BANKS | Per-bank read enable |
| bank_row_o | output | NUM_BANKS*ROW_W | Per-bank row address |
| bank_rdata_i | input | NUM_BANKS*BANK_BYTES*8 | Per-bank read data |
| line_o | output | LINE_BYTES*8 | Assembled line buffer |

## Verification
A miscounted decode or latency counter shows up as a shifted rise of the bank enables within one iteration. It also moves the done pulse off the cycle the requirement gives. A wrong iteration counter or bank-to-slot rotation shows as enables on the wrong banks, or a wrong population count, in the first cycle of an access window. The bench compares every cycle against an independent timeline model, so such faults are reported in the cycle they first appear. Capture errors appear on line_o at the done pulse. The bench's bank models return garbage until their latency has elapsed, so an early capture corrupts the line at once.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_DECODE  = 3'd1,
    S_ACCESS  = 3'd2,
    S_CAPTURE = 3'd3,
    S_DONE    = 3'd4
  } fill_state_e;

  // Number of bank sweeps needed to cover a line of 'chunks' chunks.
  function automatic int num_iters(int chunks, int banks);
    return (chunks + banks - 1) / banks;
  endfunction

  // Position of a physical bank within the current sweep, given the bank
  // that holds chunk 0 of the line.
  function automatic int slot_of_bank(int bank, int base_bank, int banks);
    return (bank >= base_bank) ? bank - base_bank : bank + banks - base_bank;
  endfunction

  // Physical bank serving a given position within a sweep.
  function automatic int bank_of_slot(int slot, int base_bank, int banks);
    int b;
    b = slot + base_bank;
    return (b >= banks) ? b - banks : b;
  endfunction

endpackage

// File: rtl/lfc_seq.sv
module lfc_seq #(
  parameter int NUM_ITERS     = 2,
  parameter int DECODE_CYCLES = 12,
  parameter int BANK_LATENCY  = 80,
  parameter int IDX_W         = 8,
  parameter int ITER_W        = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic              access_o,
  output logic              capture_o,
  output logic              done_o,
  output logic [ITER_W-1:0] iter_o,
  output logic [IDX_W-1:0]  idx_o
);
  import lfc_pkg::*;

  localparam int CNT_MAX = (DECODE_CYCLES > BANK_LATENCY) ? DECODE_CYCLES : BANK_LATENCY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fill_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [ITER_W-1:0] iter_q;
  logic [IDX_W-1:0]  idx_q;

  // Named internal events
  logic start_accept, decode_end, access_end, last_iter;
  assign start_accept = start_i && (state == S_IDLE);
  assign decode_end   = (state == S_DECODE) && (cnt == CNT_W'(DECODE_CYCLES - 1));
  assign access_end   = (state == S_ACCESS) && (cnt == CNT_W'(BANK_LATENCY - 2));
  assign last_iter    = (iter_q == ITER_W'(NUM_ITERS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      iter_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start_accept) begin
          state  <= S_DECODE;
          cnt    <= '0;
          iter_q <= '0;
          idx_q  <= idx_i;
        end
        S_DECODE: if (decode_end) begin
          state <= S_ACCESS;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_ACCESS: if (access_end) state <= S_CAPTURE;
                  else cnt <= cnt + 1'b1;
        S_CAPTURE: if (last_iter) state <= S_DONE;
                   else begin
                     iter_q <= iter_q + 1'b1;
                     cnt    <= '0;
                     state  <= S_DECODE;
                   end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state == S_DECODE) || (state == S_ACCESS) || (state == S_CAPTURE);
  assign access_o  = (state == S_ACCESS) || (state == S_CAPTURE);
  assign capture_o = (state == S_CAPTURE);
  assign done_o    = (state == S_DONE);
  assign iter_o    = iter_q;
  assign idx_o     = idx_q;

  AST_IDX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(idx_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(capture_o) && ($past(iter_o) == ITER_W'(NUM_ITERS - 1))); // R4
  AST_CAPTURE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_o) |-> ($past(state) == S_ACCESS)); // R3
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (state == S_IDLE)); // R9

endmodule

// File: rtl/lfc_bank_sel.sv
module lfc_bank_sel #(
  parameter int NUM_BANKS = 24,
  parameter int CHUNKS    = 32,
  parameter int ITER_W    = 1,
  parameter int BANK_W    = 5,
  parameter int ROW_W     = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       access_i,
  input  logic [ITER_W-1:0]          iter_i,
  input  logic [ROW_W-1:0]           base_chunk_i,
  input  logic [BANK_W-1:0]          base_bank_i,
  output logic [NUM_BANKS-1:0]       bank_en_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    int slot_v;
    int chunk_v;
    always_comb begin
      slot_v  = lfc_pkg::slot_of_bank(b, int'(base_bank_i), NUM_BANKS);
      chunk_v = int'(iter_i) * NUM_BANKS + slot_v;
    end
    assign bank_en_o[b] = access_i && (chunk_v < CHUNKS);
    assign bank_row_o[b*ROW_W +: ROW_W] = ROW_W'((int'(base_chunk_i) + chunk_v) / NUM_BANKS);
  end

  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i && $past(access_i)) |-> $stable(bank_en_o) && $stable(bank_row_o)); // R3

endmodule

// File: rtl/lfc_line_buf.sv
module lfc_line_buf #(
  parameter int NUM_BANKS = 24,
  parameter int CHUNKS    = 32,
  parameter int W         = 16,
  parameter int ITER_W    = 1,
  parameter int BANK_W    = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture_i,
  input  logic [ITER_W-1:0]      iter_i,
  input  logic [BANK_W-1:0]      base_bank_i,
  input  logic [NUM_BANKS*W-1:0] bank_data_i,
  output logic [CHUNKS*W-1:0]    line_o
);
  for (genvar j = 0; j < CHUNKS; j++) begin : g_chunk
    localparam int IT   = j / NUM_BANKS;
    localparam int SLOT = j % NUM_BANKS;
    int src_v;
    logic [W-1:0] q;
    always_comb src_v = lfc_pkg::bank_of_slot(SLOT, int'(base_bank_i), NUM_BANKS);
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (capture_i && (iter_i == ITER_W'(IT))) q <= bank_data_i[src_v*W +: W];
    end
    assign line_o[j*W +: W] = q;
  end

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(line_o)); // R7

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int LINE_BYTES    = 64,
  parameter int NUM_BANKS     = 24,
  parameter int BANK_BYTES    = 2,
  parameter int DECODE_CYCLES = NUM_BANKS / 2,
  parameter int BANK_LATENCY  = 80,
  parameter int IDX_W         = 8,
  localparam int CHUNKS = LINE_BYTES / BANK_BYTES,
  localparam int ROW_W  = IDX_W + $clog2(CHUNKS) + 1,
  localparam int W      = BANK_BYTES * 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [IDX_W-1:0]           line_idx_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [NUM_BANKS-1:0]       bank_en_o,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
  input  logic [NUM_BANKS*W-1:0]     bank_rdata_i,
  output logic [LINE_BYTES*8-1:0]    line_o
);
  localparam int NUM_ITERS   = lfc_pkg::num_iters(CHUNKS, NUM_BANKS);
  localparam int LAST_CHUNKS = CHUNKS - (NUM_ITERS - 1) * NUM_BANKS;
  localparam int ITER_W      = (NUM_ITERS > 1) ? $clog2(NUM_ITERS) : 1;
  localparam int BANK_W      = $clog2(NUM_BANKS);

  logic              access, capture;
  logic [ITER_W-1:0] iter;
  logic [IDX_W-1:0]  idx_q;
  logic [ROW_W-1:0]  base_chunk;
  logic [BANK_W-1:0] base_bank;

  assign base_chunk = ROW_W'(idx_q) * ROW_W'(CHUNKS);
  assign base_bank  = BANK_W'(base_chunk % ROW_W'(NUM_BANKS));

  lfc_seq #(
    .NUM_ITERS(NUM_ITERS), .DECODE_CYCLES(DECODE_CYCLES),
    .BANK_LATENCY(BANK_LATENCY), .IDX_W(IDX_W), .ITER_W(ITER_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_i(line_idx_i),
    .busy_o(busy_o), .access_o(access), .capture_o(capture), .done_o(done_o),
    .iter_o(iter), .idx_o(idx_q)
  );

  lfc_bank_sel #(
    .NUM_BANKS(NUM_BANKS), .CHUNKS(CHUNKS), .ITER_W(ITER_W),
    .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .access_i(access), .iter_i(iter),
    .base_chunk_i(base_chunk), .base_bank_i(base_bank),
    .bank_en_o(bank_en_o), .bank_row_o(bank_row_o)
  );

  lfc_line_buf #(
    .NUM_BANKS(NUM_BANKS), .CHUNKS(CHUNKS), .W(W),
    .ITER_W(ITER_W), .BANK_W(BANK_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .capture_i(capture), .iter_i(iter),
    .base_bank_i(base_bank), .bank_data_i(bank_rdata_i), .line_o(line_o)
  );

  AST_LAST_SWEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (iter == ITER_W'(NUM_ITERS - 1))) |-> ($countones(bank_en_o) == LAST_CHUNKS)); // R6
  AST_FULL_SWEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (iter != ITER_W'(NUM_ITERS - 1))) |-> ($countones(bank_en_o) == NUM_BANKS)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && (bank_en_o == '0)); // R4

endmodule

// File: tb/line_fill_ctrl_tb.sv
module line_fill_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_BYTES = 64;
  localparam int K          = 24;
  localparam int C          = 2;
  localparam int D          = K / 2;
  localparam int L          = 80;
  localparam int IDX_W      = 8;
  localparam int CHUNKS     = LINE_BYTES / C;
  localparam int W          = C * 8;
  localparam int ROW_W      = IDX_W + $clog2(CHUNKS) + 1;
  localparam int N          = (LINE_BYTES + K * C - 1) / (K * C);
  localparam int TOTAL      = N * (D + L);
  localparam int LW         = LINE_BYTES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [IDX_W-1:0] line_idx_i = '0;
  logic busy_o, done_o;
  logic [K-1:0] bank_en_o;
  logic [K*ROW_W-1:0] bank_row_o;
  logic [K*W-1:0] bank_rdata_i;
  logic [LW-1:0] line_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_fill_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_idx_i(line_idx_i),
    .busy_o(busy_o), .done_o(done_o), .bank_en_o(bank_en_o),
    .bank_row_o(bank_row_o), .bank_rdata_i(bank_rdata_i), .line_o(line_o)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Reference memory content: a hash of the global chunk index.
  function automatic logic [W-1:0] chunk_word(int g);
    logic [31:0] h;
    logic [63:0] hh;
    h  = g * 32'h9E3779B1 ^ 32'h2545F491;
    hh = {h, ~h};
    return hh[W-1:0];
  endfunction

  function automatic logic [LW-1:0] exp_line(int idx);
    logic [LW-1:0] v;
    v = '0;
    for (int j = 0; j < CHUNKS; j++) v[j*W +: W] = chunk_word(idx * CHUNKS + j);
    return v;
  endfunction

  // Bank models: data only valid once enabled for L cycles (R8)
  int bcnt [K];
  always @(posedge clk) begin
    for (int b = 0; b < K; b++) bcnt[b] <= bank_en_o[b] ? bcnt[b] + 1 : 0;
  end
  always_comb begin
    for (int b = 0; b < K; b++) begin
      if (bank_en_o[b] && bcnt[b] >= L - 1)
        bank_rdata_i[b*W +: W] = chunk_word(int'(bank_row_o[b*ROW_W +: ROW_W]) * K + b);
      else
        bank_rdata_i[b*W +: W] = ~chunk_word(int'(bank_row_o[b*ROW_W +: ROW_W]) * K + b);
    end
  end

  // Behavioural timeline model
  int m_t = -1;
  bit m_done = 1'b0;
  int m_idx = 0;
  int m_fills = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = -1; m_done = 1'b0;
    end else if (m_done) begin
      m_done = 1'b0;
    end else if (m_t < 0) begin
      if (start_i) begin m_t = 0; m_idx = int'(line_idx_i); end
    end else begin
      m_t++;
      if (m_t == TOTAL) begin m_t = -1; m_done = 1'b1; m_fills++; end
    end
  end

  // Expected enables and rows from the timeline position
  always @(negedge clk) begin
    if (rst_n) begin
      logic [K-1:0] ee;
      logic [K*ROW_W-1:0] er, ar;
      int base, it, w, j;
      ee = '0; er = '0; ar = '0;
      base = m_idx * CHUNKS;
      if (m_t >= 0) begin
        it = m_t / (D + L);
        w  = m_t % (D + L);
        for (int b = 0; b < K; b++) begin
          j = it * K + ((b - base % K + K) % K);
          if (w >= D && j < CHUNKS) begin
            ee[b] = 1'b1;
            er[b*ROW_W +: ROW_W] = ROW_W'((base + j) / K);
          end
        end
      end
      for (int b = 0; b < K; b++)
        if (bank_en_o[b]) ar[b*ROW_W +: ROW_W] = bank_row_o[b*ROW_W +: ROW_W];
      chk(busy_o == (m_t >= 0), "R4 busy", LW'(busy_o), LW'(m_t >= 0));
      chk(done_o == m_done, "R4 done", LW'(done_o), LW'(m_done));
      chk(bank_en_o == ee, "R3/R6 bank enables", LW'(bank_en_o), LW'(ee));
      chk(ar == er, "R5 bank rows", LW'(ar), LW'(er));
      if (m_done) chk(line_o == exp_line(m_idx), "R7/R8 line at done", line_o, exp_line(m_idx));
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      chk(1'b0, "watchdog", LW'(cyc), '0);
      finish_run();
    end
  end

  // One fill; optional stray start during busy at busy cycle glitch_at.
  task automatic do_fill(input int idx, input int glitch_at, input int glitch_idx);
    int ncyc;
    @(negedge clk);
    start_i = 1'b1; line_idx_i = IDX_W'(idx);
    @(negedge clk);
    start_i = 1'b0;
    ncyc = 0;
    while (!done_o && ncyc < 4 * TOTAL) begin
      if (busy_o) ncyc++;
      if (glitch_at > 0 && ncyc == glitch_at) begin
        start_i = 1'b1; line_idx_i = IDX_W'(glitch_idx);
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(ncyc == TOTAL, "R4 busy length", LW'(ncyc), LW'(TOTAL));
    chk(line_o == exp_line(idx), "R7 line content", line_o, exp_line(idx));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && bank_en_o == '0 && line_o == '0, "R1 in reset",
        LW'({busy_o, done_o, bank_en_o}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && bank_en_o == '0 && line_o == '0, "R1 after reset",
        LW'({busy_o, done_o, bank_en_o}), '0);

    do_fill(0, 0, 0);        // start bank 0, default timing 184
    do_fill(5, 0, 0);        // base bank 16, wraps
    do_fill(255, 0, 0);      // top line index
    do_fill(3, 50, 77);      // R2: stray start while busy
    @(negedge clk);
    chk(line_o == exp_line(3), "R7 line held in idle", line_o, exp_line(3));
    chk(!busy_o, "R2 no restart from stray start", LW'(busy_o), '0);

    // R2 and R9: start held high across the done cycle
    @(negedge clk);
    start_i = 1'b1; line_idx_i = IDX_W'(9);
    @(negedge clk);
    line_idx_i = IDX_W'(11);
    while (!done_o) @(negedge clk);
    chk(line_o == exp_line(9), "R2 line unaffected by held start", line_o, exp_line(9));
    @(negedge clk);
    chk(!busy_o && !done_o, "R9 idle after done", LW'({busy_o, done_o}), '0);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R9 restart from held start", LW'(busy_o), LW'(1));
    while (!done_o) @(negedge clk);
    chk(line_o == exp_line(11), "R9 second line", line_o, exp_line(11));
    @(negedge clk);
    chk(m_fills == 6, "R9 fill count", LW'(m_fills), LW'(6));
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule